// File: doc/BRIEF.md
# Serial Flash Command Guard with Layered Write Protection

This block is the command front end of a serial flash memory. It watches a mode-0 serial slave link (select, clock, data in, data out), decodes the instruction byte and any address bytes, and keeps the status register. For each write-class command it decides whether the command may run. An accepted program or erase command goes to the array back end as an opcode and a 24-bit address. A refused command produces a one-cycle reject strobe. A status write is carried out inside the block.

Protection works in layers. A write-enable latch must be armed before any write-class command. Three protect bits mark the top part of an eight-sector array as protected, and bulk erase needs all three to be clear. A lock bit in the status register, together with a low level on the write-protect pin, freezes the lock bit and the protect bits. The serial pins are sampled in the system clock domain through two-flop synchronizers. The serial clock must therefore run at well under a quarter of the system clock rate.

Accepted program and erase commands leave the block on a valid/ready handoff. `cmd_valid` stays high, with opcode and address held, until the back end raises `cmd_ready`. The back end may hold `cmd_ready` low for as long as it needs. A program or erase command that commits while a handoff is still pending is refused.

Top module: `spi_flash_guard`

## Requirements
- R1: After reset the status byte reads 0x00 (with `busy` low), `cmd_valid` is low and no reject strobe occurs.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it.
- R3: Write status (0x01), page program (0x02), sector erase (0xD8) and bulk erase (0xC7) are refused when the latch is clear. The latch is clear after any of these commands, whether it was accepted or refused.
- R4: An accepted write status copies data bit 7 to the lock bit (status bit 7) and data bits 4:2 to the protect bits (status bits 4:2). Status bits 6 and 5 always read 0, and status bit 0 reflects the `busy` input.
- R5: Page program and sector erase are refused when the address sector (address bits 18:16) is protected. Protect value 0 protects nothing, 1 protects sector 7, 2 protects sectors 6 and 7, 3 protects sectors 4 to 7, and 4 to 7 protect every sector.
- R6: Bulk erase is issued only when all three protect bits are 0. Otherwise it is refused.
- R7: While the lock bit is 1 and `wp_n` is low, a write status is refused and the lock and protect bits keep their values. With `wp_n` high, the same write succeeds.
- R8: For opcode 0x05, `miso_oe` stays low while the opcode is shifted in. After that, the status byte is driven MSB first, changing on falling `sclk`, and it repeats for as long as select stays low.
- R9: A command commits only on the rising edge of select, and only after a whole number of bytes of the correct length: 1 byte for 0x06, 0x04 and 0xC7; 2 bytes for 0x01; 4 bytes for 0xD8; at least 4 bytes for 0x02. Any other frame has no effect and leaves the latch as it was.
- R10: `cmd_valid` holds, with `cmd_opcode` and `cmd_addr` stable, until `cmd_ready` is high. A program or erase command that commits while `cmd_valid` is high is refused.
- R11: The 24-bit address follows the opcode MSB first, and it appears unchanged on `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for `miso` (low means high impedance) |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Back end busy, shown as status bit 0 |
| cmd_valid | output | 1 | Accepted program or erase command pending |
| cmd_ready | input | 1 | Back end takes the pending command |
| cmd_opcode | output | 8 | Opcode of the pending command |
| cmd_addr | output | 24 | Address of the pending command |
| rej_pulse | output | 1 | One-cycle strobe for a refused command |
| rej_opcode | output | 8 | Opcode of the refused command |

## Verification
The hardest state to reach is hardware-protected mode. To get there, the lock bit must first be written while the pin is still low and the bits are still writable. After that, a second status write under the same pin level must be refused and must leave every protect bit unchanged. The stimulus arms the latch and writes lock plus protect value 1, then repeats the write of zeros. It then raises the pin and repeats the write once more, and after each step it reads the status back over the serial link. Framing corner cases are also covered: a valid opcode followed by three stray bits, and a second erase that arrives while the back end is still holding off the first.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERS = 8'hD8;
  localparam logic [7:0] OP_BERS = 8'hC7;

  // status byte layout (decoded by software, so positions are fixed)
  localparam int ST_LOCK = 7;
  localparam int ST_BPHI = 4;
  localparam int ST_BPLO = 2;
  localparam int ST_WEL  = 1;
  localparam int ST_WIP  = 0;

  typedef enum logic [1:0] {
    LEN_ONE,
    LEN_TWO,
    LEN_FOUR,
    LEN_FOUR_PLUS
  } len_rule_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              sel,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              cs_rise,
  output logic              first_done,
  output logic [7:0]        cur_byte,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic [2:0]        byte_cnt,
  output logic              aligned
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic       sclk_d, cs_d;
  logic [6:0] shreg;
  logic [2:0] bit_idx;

  assign sel       = ~cs_n_s;
  assign sclk_rise = sel & sclk_s & ~sclk_d;
  assign sclk_fall = sel & ~sclk_s & sclk_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign cur_byte  = {shreg, mosi_s};
  assign first_done = sclk_rise && (bit_idx == 3'd7) && (byte_cnt == 3'd0);
  assign aligned   = (bit_idx == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_idx  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      addr     <= '0;
      wdata    <= '0;
    end else if (!sel) begin
      bit_idx  <= '0;
      byte_cnt <= '0;
    end else if (sclk_rise) begin
      shreg   <= cur_byte[6:0];
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
        if (byte_cnt == 3'd0) opcode <= cur_byte;
        if (byte_cnt == 3'd1) wdata <= cur_byte;
        if (byte_cnt >= 3'd1 && byte_cnt <= 3'(ADDR_BYTES))
          addr <= {addr[ADDR_W-9:0], cur_byte};
      end
    end
  end
endmodule

// File: rtl/prot_decide.sv
module prot_decide
  import spi_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ARRAY_AW = 19,
  parameter int SECTOR_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        byte_cnt,
  input  logic              aligned,
  input  logic              wp_n_s,
  input  logic              busy,
  input  logic              cmd_ready,
  output logic [7:0]        status,
  output logic              lock_q,
  output logic [2:0]        bp_q,
  output logic              wel_q,
  output logic              hw_locked,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rej_pulse,
  output logic [7:0]        rej_opcode
);
  localparam int NSEC = 1 << SECTOR_BITS;

  logic              len_ok, known_wr, allowed, in_prot;
  logic [SECTOR_BITS-1:0] sector;
  len_rule_e         rule;

  assign hw_locked = lock_q & ~wp_n_s;
  assign sector    = addr[ARRAY_AW-1 -: SECTOR_BITS];
  assign status    = {lock_q, 2'b00, bp_q, wel_q, busy};

  function automatic logic sector_locked(input logic [2:0] b,
                                         input logic [SECTOR_BITS-1:0] s);
    logic [SECTOR_BITS:0] span;
    if (b == 3'd0) span = '0;
    else if (int'(b) > SECTOR_BITS) span = (SECTOR_BITS+1)'(NSEC);
    else span = (SECTOR_BITS+1)'(1) << (b - 3'd1);
    return ({1'b0, s} >= ((SECTOR_BITS+1)'(NSEC) - span));
  endfunction

  assign in_prot = sector_locked(bp_q, sector);

  always_comb begin
    rule     = LEN_ONE;
    known_wr = 1'b0;
    unique case (opcode)
      OP_WRSR: begin rule = LEN_TWO;       known_wr = 1'b1; end
      OP_PROG: begin rule = LEN_FOUR_PLUS; known_wr = 1'b1; end
      OP_SERS: begin rule = LEN_FOUR;      known_wr = 1'b1; end
      OP_BERS: begin rule = LEN_ONE;       known_wr = 1'b1; end
      default: rule = LEN_ONE;
    endcase
    unique case (rule)
      LEN_ONE:       len_ok = (byte_cnt == 3'd1);
      LEN_TWO:       len_ok = (byte_cnt == 3'd2);
      LEN_FOUR:      len_ok = (byte_cnt == 3'd4);
      LEN_FOUR_PLUS: len_ok = (byte_cnt >= 3'd4);
      default:       len_ok = 1'b0;
    endcase
    len_ok = len_ok & aligned;
  end

  always_comb begin
    allowed = wel_q;
    unique case (opcode)
      OP_WRSR: allowed = wel_q & ~hw_locked;
      OP_PROG,
      OP_SERS: allowed = wel_q & ~in_prot & ~cmd_valid;
      OP_BERS: allowed = wel_q & (bp_q == 3'd0) & ~cmd_valid;
      default: allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      bp_q       <= '0;
      wel_q      <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_opcode <= '0;
      cmd_addr   <= '0;
      rej_pulse  <= 1'b0;
      rej_opcode <= '0;
    end else begin
      rej_pulse <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (commit && len_ok) begin
        if (opcode == OP_WREN) wel_q <= 1'b1;
        else if (opcode == OP_WRDI) wel_q <= 1'b0;
        else if (known_wr) begin
          wel_q <= 1'b0;
          if (!allowed) begin
            rej_pulse  <= 1'b1;
            rej_opcode <= opcode;
          end else if (opcode == OP_WRSR) begin
            lock_q <= wdata[ST_LOCK];
            bp_q   <= wdata[ST_BPHI:ST_BPLO];
          end else begin
            cmd_valid  <= 1'b1;
            cmd_opcode <= opcode;
            cmd_addr   <= (opcode == OP_BERS) ? '0 : addr;
          end
        end
      end
    end
  end
endmodule

// File: rtl/status_stream.sv
module status_stream (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sclk_fall,
  input  logic       start,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_oe
);
  logic       active;
  logic [2:0] idx;
  logic [7:0] snap;

  assign miso_oe = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= 3'd7;
      snap   <= '0;
      miso   <= 1'b0;
    end else if (!sel) begin
      active <= 1'b0;
      miso   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= 3'd7;
    end else if (active && sclk_fall) begin
      if (idx == 3'd7) begin
        snap <= status;
        miso <= status[7];
      end else begin
        miso <= snap[idx];
      end
      idx <= idx - 3'd1;
    end
  end
endmodule

// File: rtl/spi_flash_guard.sv
module spi_flash_guard
  import spi_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ARRAY_AW = 19,
  parameter int SECTOR_BITS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              wp_n,
  input  logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rej_pulse,
  output logic [7:0]        rej_opcode
);
  logic cs_n_s, sclk_s, mosi_s, wp_n_s;
  logic sel, sclk_rise, sclk_fall, cs_rise, first_done, aligned;
  logic [7:0] cur_byte, opcode, wdata, status;
  logic [ADDR_W-1:0] addr;
  logic [2:0] byte_cnt, bp_q;
  logic lock_q, wel_q, hw_locked;

  pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, mosi, wp_n}),
    .q({cs_n_s, sclk_s, mosi_s, wp_n_s})
  );

  spi_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .first_done(first_done), .cur_byte(cur_byte),
    .opcode(opcode), .addr(addr), .wdata(wdata),
    .byte_cnt(byte_cnt), .aligned(aligned)
  );

  prot_decide #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW),
                .SECTOR_BITS(SECTOR_BITS)) u_decide (
    .clk(clk), .rst_n(rst_n),
    .commit(cs_rise), .opcode(opcode), .addr(addr), .wdata(wdata),
    .byte_cnt(byte_cnt), .aligned(aligned), .wp_n_s(wp_n_s),
    .busy(busy), .cmd_ready(cmd_ready), .status(status),
    .lock_q(lock_q), .bp_q(bp_q), .wel_q(wel_q), .hw_locked(hw_locked),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .rej_pulse(rej_pulse), .rej_opcode(rej_opcode)
  );

  status_stream u_stream (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_fall(sclk_fall),
    .start(first_done && (cur_byte == OP_RDSR)),
    .status(status), .miso(miso), .miso_oe(miso_oe)
  );
endmodule

// File: rtl/spi_flash_guard_chk.sv
module spi_flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       miso_oe,
  input logic       hw_locked,
  input logic       lock_q,
  input logic [2:0] bp_q,
  input logic       wel_q,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_opcode,
  input logic [23:0] cmd_addr,
  input logic       rej_pulse
);
  // R7
  hw_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_locked |=> $stable({lock_q, bp_q}));

  // R3
  issue_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(wel_q) && !wel_q);

  // R3
  reject_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> !wel_q);

  // R6
  bulk_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_opcode == 8'hC7) |-> $past(bp_q) == 3'd0);

  // R10
  handoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_opcode));

  // R8
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe);
endmodule

bind spi_flash_guard spi_flash_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .miso_oe(miso_oe),
  .hw_locked(hw_locked), .lock_q(lock_q), .bp_q(bp_q), .wel_q(wel_q),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
  .cmd_addr(cmd_addr), .rej_pulse(rej_pulse)
);

// File: tb/spi_flash_guard_test.sv
module spi_flash_guard_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sclk, mosi, miso, miso_oe, wp_n, busy;
  logic cmd_valid, cmd_ready, rej_pulse;
  logic [7:0] cmd_opcode, rej_opcode;
  logic [23:0] cmd_addr;

  spi_flash_guard uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .rej_pulse(rej_pulse), .rej_opcode(rej_opcode)
  );

  int n_chk = 0, n_fail = 0, rej_seen = 0;
  logic [7:0] last_rej = 8'h00;
  bit done = 0;

  always @(posedge clk) if (rej_pulse) begin rej_seen++; last_rej = rej_opcode; end

  // {bp[2:0], opcode[7:0], addr[23:0], expect_issue}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 8'hD8, 24'h070000, 1'b1},
    {3'd1, 8'hD8, 24'h070000, 1'b0},
    {3'd1, 8'hD8, 24'h060000, 1'b1},
    {3'd2, 8'h02, 24'h060000, 1'b0},
    {3'd2, 8'h02, 24'h05FFFF, 1'b1},
    {3'd3, 8'hD8, 24'h040000, 1'b0},
    {3'd3, 8'hD8, 24'h03FFFF, 1'b1},
    {3'd4, 8'hD8, 24'h000000, 1'b0},
    {3'd7, 8'h02, 24'h000100, 1'b0},
    {3'd0, 8'hC7, 24'h000000, 1'b1},
    {3'd5, 8'hC7, 24'h000000, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input bit b, output bit r);
    mosi = b; tick(HALF); r = miso; sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin bit t; xbit(b[i], t); r[i] = t; end
  endtask

  task automatic cs_on();  cs_n = 1'b0; tick(HALF); endtask
  task automatic cs_off(); tick(HALF); cs_n = 1'b1; tick(12); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; cs_on(); xbyte(op, r); cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r; cs_on(); xbyte(8'h01, r); xbyte(v, r); cs_off();
  endtask

  task automatic cmd_addr3(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    cs_on(); xbyte(op, r);
    if (op != 8'hC7) begin
      xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
      if (op == 8'h02) xbyte(8'hA5, r);
    end
    cs_off();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] r; cs_on(); xbyte(8'h05, r); xbyte(8'h00, v); cs_off();
  endtask

  task automatic take_cmd();
    cmd_ready = 1'b1; tick(1); cmd_ready = 1'b0; tick(1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] st, r;
    int r0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    wp_n = 1'b1; busy = 1'b0; cmd_ready = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk(cmd_valid == 1'b0 && rej_seen == 0, "R1 idle outputs", {cmd_valid, 8'(rej_seen)}, 0);
    rdsr(st);
    chk(st == 8'h00, "R1 status after reset", st, 8'h00);

    // vector table: protection by region and bulk erase gate
    foreach (VEC[k]) begin
      logic [2:0] b; logic [7:0] op; logic [23:0] a; logic ex;
      {b, op, a, ex} = VEC[k];
      cmd1(8'h06); wrsr({3'b000, b, 2'b00});
      cmd1(8'h06);
      r0 = rej_seen;
      cmd_addr3(op, a);
      if (op == 8'hC7)
        chk(cmd_valid == ex && rej_seen == r0 + (ex ? 0 : 1), "R6 bulk gate",
            {cmd_valid, 8'(rej_seen - r0)}, {ex, 8'(ex ? 0 : 1)});
      else
        chk(cmd_valid == ex && rej_seen == r0 + (ex ? 0 : 1), "R5 region gate",
            {cmd_valid, a}, {ex, a});
      if (ex) begin
        chk(cmd_opcode == op && cmd_addr == (op == 8'hC7 ? 24'h0 : a),
            "R11 address handoff", cmd_addr, a);
        take_cmd();
      end
    end

    // restore bp to 0
    cmd1(8'h06); wrsr(8'h00);

    // R2 latch set and clear
    cmd1(8'h06); rdsr(st);
    chk(st == 8'h02, "R2 write enable sets bit1", st, 8'h02);
    cmd1(8'h04); rdsr(st);
    chk(st == 8'h00, "R2 write disable clears", st, 8'h00);

    // R3 no latch: erase refused
    r0 = rej_seen;
    cmd_addr3(8'hD8, 24'h010000);
    chk(rej_seen == r0 + 1 && cmd_valid == 1'b0 && last_rej == 8'hD8,
        "R3 erase without latch", last_rej, 8'hD8);

    // R4 status field layout, bits 6 and 5 and wel/wip ignored
    cmd1(8'h06); wrsr(8'h63); rdsr(st);
    chk(st == 8'h00, "R4 ignored bits", st, 8'h00);
    busy = 1'b1; tick(4); rdsr(st); busy = 1'b0;
    chk(st == 8'h01, "R4 busy shows as bit0", st, 8'h01);

    // R8 stream: opcode phase undriven, status repeats
    cmd1(8'h06); wrsr(8'h0C);
    cs_on();
    begin
      bit t; bit oe_mid;
      xbit(1'b0, t); xbit(1'b0, t); xbit(1'b0, t); xbit(1'b0, t);
      oe_mid = miso_oe;
      xbit(1'b0, t); xbit(1'b1, t); xbit(1'b0, t); xbit(1'b1, t);
      chk(oe_mid == 1'b0, "R8 undriven during opcode", oe_mid, 0);
    end
    for (int j = 0; j < 3; j++) begin
      xbyte(8'h00, r);
      chk(r == 8'h0C && miso_oe, "R8 repeated status byte", r, 8'h0C);
    end
    cs_off();
    chk(miso_oe == 1'b0, "R8 released after select", miso_oe, 0);

    // R7 hardware lock
    wp_n = 1'b0; tick(4);
    cmd1(8'h06); wrsr(8'h84); rdsr(st);
    chk(st == 8'h84, "R7 lock written while unlocked", st, 8'h84);
    r0 = rej_seen;
    cmd1(8'h06); wrsr(8'h00); rdsr(st);
    chk(st == 8'h84 && rej_seen == r0 + 1, "R7 locked write refused", st, 8'h84);
    wp_n = 1'b1; tick(4);
    cmd1(8'h06); wrsr(8'h00); rdsr(st);
    chk(st == 8'h00, "R7 pin high allows write", st, 8'h00);

    // R9 stray bits discard
    cs_on(); xbyte(8'h06, r);
    begin bit t; xbit(1'b1, t); xbit(1'b0, t); xbit(1'b1, t); end
    cs_off(); rdsr(st);
    chk(st == 8'h00, "R9 partial frame ignored", st, 8'h00);
    cmd1(8'h06);
    r0 = rej_seen;
    cs_on(); xbyte(8'hD8, r); xbyte(8'h01, r); cs_off();
    rdsr(st);
    chk(st == 8'h02 && rej_seen == r0 && !cmd_valid, "R9 short erase ignored", st, 8'h02);

    // R10 back-pressure
    cmd_addr3(8'hD8, 24'h020000);
    chk(cmd_valid && cmd_addr == 24'h020000, "R10 first issue", cmd_addr, 24'h020000);
    cmd1(8'h06); r0 = rej_seen;
    cmd_addr3(8'hD8, 24'h030000);
    chk(rej_seen == r0 + 1 && cmd_valid && cmd_addr == 24'h020000,
        "R10 pending refuses second", cmd_addr, 24'h020000);
    tick(20);
    chk(cmd_valid && cmd_addr == 24'h020000, "R10 held without ready", cmd_addr, 24'h020000);
    take_cmd();
    chk(cmd_valid == 1'b0, "R10 released by ready", cmd_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule